// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a small stored-program processor with a four-instruction set and one shared internal bus. Its state is an accumulator, a program counter, an instruction register, a memory address register, a memory data register and a temporary register that captures the adder result. A hardwired step sequencer raises named control points one step at a time. Each step either drives a value onto the bus and loads it into a register, or starts a memory read, a memory write or a program counter increment.

A 64-word program and data memory sits inside the block. While reset is held, a testbench or a boot agent fills this memory through the preload port. Once reset is released the processor fetches from address 0. Three debug outputs show the accumulator, the program counter and the current control step. Software can only observe memory contents by loading a word back into the accumulator.

An instruction word is DATA_W bits wide. The top two bits hold the opcode and the remaining bits hold the operand address. Every instruction starts with three fetch steps and then runs one to four execute steps, depending on the opcode.

Top module: `accpu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter, the accumulator and the step counter read 0 after that edge.
- R2: Every instruction starts with fetch steps 0, 1 and 2. The program counter advances by exactly one during fetch. The step counter is back at 0 once each instruction finishes.
- R3: Opcode 00 (load, word bits [7:6] = 00, bits [5:0] = address) sets the accumulator to the memory word at the address. The instruction takes 6 clock cycles.
- R4: Opcode 01 (add) sets the accumulator to the accumulator plus the memory word at the address, modulo 2^DATA_W. The instruction takes 7 cycles and its last step has index 6.
- R5: Opcode 10 (store) writes the accumulator into the memory word at the address and leaves the accumulator unchanged. The instruction takes 6 cycles.
- R6: Opcode 11 (branch-if-zero) with an accumulator of 0 loads the address field into the program counter. The instruction takes 4 cycles.
- R7: Opcode 11 with a nonzero accumulator leaves the accumulator unchanged and leaves the program counter at the incremented fetch value. The instruction takes 4 cycles.
- R8: At most one source drives the internal bus in any step.
- R9: The preload port writes memory only while `rst` is high. While `rst` is low, preload writes have no effect on memory.
- R10: The step counter never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| pre_we | input | 1 | Preload write enable, honoured only while rst is high |
| pre_addr | input | 6 | Preload word address |
| pre_data | input | 8 | Preload word value |
| dbg_acc | output | 8 | Accumulator register |
| dbg_pc | output | 6 | Program counter register |
| dbg_step | output | 3 | Current control step |

## Verification
Assertions check the following on every cycle:
- the bus has a single driver;
- the fetch steps advance in order and the step counter stays within bounds;
- the program counter grows by one on an increment step;
- the accumulator holds its value whenever it is not being loaded;
- a taken branch copies the operand field into the program counter;
- reset clears the visible state.

Only the bench scenarios can show that each opcode produces the right arithmetic result, and that a stored word can be read back by a later load. They also show that each instruction ends after exactly its cycle count, and that preload traffic during a run leaves memory untouched. These scenarios are a directed program that covers adder wrap-around and both branch outcomes, plus random programs compared against an instruction-level model.

// File: rtl/accpu_pkg.sv
package accpu_pkg;

  localparam int unsigned OP_W           = 2;
  localparam int unsigned FETCH_STEPS    = 3;
  localparam int unsigned MAX_EXEC_STEPS = 4;
  localparam int unsigned LAST_STEP      = FETCH_STEPS + MAX_EXEC_STEPS - 1;
  localparam int unsigned STEP_W         = $clog2(LAST_STEP + 1);

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_BRZ   = 2'b11
  } opcode_e;

  // One bit per control point of the shared-bus datapath
  typedef struct packed {
    logic acc_ld;
    logic acc_drv;
    logic sum_sel;
    logic ir_ld;
    logic ir_drv;
    logic mar_ld;
    logic mdr_ld;
    logic mdr_drv;
    logic pc_ld;
    logic pc_drv;
    logic pc_inc;
    logic mem_rd;
    logic tmp_drv;
    logic mem_wr;
  } ctrl_t;

endpackage

// File: rtl/accpu_wordmem.sv
module accpu_wordmem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Synchronous write, asynchronous read: maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/accpu_sequencer.sv
module accpu_sequencer
  import accpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  opcode_e           opcode,
  input  logic              acc_zero,
  output ctrl_t             ctrl,
  output logic [STEP_W-1:0] step
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] ex_idx;
  logic              last;

  assign ex_idx = step_q - STEP_W'(FETCH_STEPS);

  always_comb begin
    ctrl = '0;
    last = 1'b0;
    if (step_q == STEP_W'(0)) begin
      ctrl.pc_drv = 1'b1;
      ctrl.mar_ld = 1'b1;
    end else if (step_q == STEP_W'(1)) begin
      ctrl.mem_rd = 1'b1;
      ctrl.pc_inc = 1'b1;
    end else if (step_q == STEP_W'(2)) begin
      ctrl.mdr_drv = 1'b1;
      ctrl.ir_ld   = 1'b1;
    end else begin
      unique case (opcode)
        OP_LOAD: begin
          case (ex_idx)
            STEP_W'(0): begin ctrl.ir_drv = 1'b1; ctrl.mar_ld = 1'b1; end
            STEP_W'(1): ctrl.mem_rd = 1'b1;
            STEP_W'(2): begin ctrl.mdr_drv = 1'b1; ctrl.acc_ld = 1'b1; last = 1'b1; end
            default:    last = 1'b1;
          endcase
        end
        OP_ADD: begin
          case (ex_idx)
            STEP_W'(0): begin ctrl.ir_drv = 1'b1; ctrl.mar_ld = 1'b1; end
            STEP_W'(1): ctrl.mem_rd = 1'b1;
            STEP_W'(2): begin ctrl.mdr_drv = 1'b1; ctrl.sum_sel = 1'b1; end
            STEP_W'(3): begin ctrl.tmp_drv = 1'b1; ctrl.acc_ld = 1'b1; last = 1'b1; end
            default:    last = 1'b1;
          endcase
        end
        OP_STORE: begin
          case (ex_idx)
            STEP_W'(0): begin ctrl.ir_drv = 1'b1; ctrl.mar_ld = 1'b1; end
            STEP_W'(1): begin ctrl.acc_drv = 1'b1; ctrl.mdr_ld = 1'b1; end
            STEP_W'(2): begin ctrl.mem_wr = 1'b1; last = 1'b1; end
            default:    last = 1'b1;
          endcase
        end
        OP_BRZ: begin
          if (acc_zero) begin
            ctrl.ir_drv = 1'b1;
            ctrl.pc_ld  = 1'b1;
          end
          last = 1'b1;
        end
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else if (last) begin
      step_q <= '0;
    end else begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  assign step = step_q;

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step_q < STEP_W'(FETCH_STEPS)) |=> (step_q == $past(step_q) + STEP_W'(1))); // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    step_q <= STEP_W'(LAST_STEP)); // R10

  AST_ACC_LOAD_ENDS_INSTR: assert property (@(posedge clk) disable iff (rst)
    ctrl.acc_ld |=> (step_q == '0)); // R10

endmodule

// File: rtl/accpu_datapath.sv
module accpu_datapath
  import accpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  output opcode_e           opcode,
  output logic              acc_zero,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);

  localparam int unsigned HI_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] acc_q, ir_q, mdr_q, tmp_q;
  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [DATA_W-1:0] bus;

  // Shared bus: the sequencer raises at most one drive point per step
  always_comb begin
    if (ctrl.acc_drv) begin
      bus = acc_q;
    end else if (ctrl.mdr_drv) begin
      bus = mdr_q;
    end else if (ctrl.pc_drv) begin
      bus = {{HI_W{1'b0}}, pc_q};
    end else if (ctrl.tmp_drv) begin
      bus = tmp_q;
    end else if (ctrl.ir_drv) begin
      bus = {{HI_W{1'b0}}, ir_q[ADDR_W-1:0]};
    end else begin
      bus = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      tmp_q <= '0;
    end else begin
      if (ctrl.acc_ld) acc_q <= bus;
      if (ctrl.ir_ld)  ir_q  <= bus;
      if (ctrl.mar_ld) mar_q <= bus[ADDR_W-1:0];
      if (ctrl.mem_rd) begin
        mdr_q <= mem_rdata;
      end else if (ctrl.mdr_ld) begin
        mdr_q <= bus;
      end
      if (ctrl.pc_ld) begin
        pc_q <= bus[ADDR_W-1:0];
      end else if (ctrl.pc_inc) begin
        pc_q <= pc_q + ADDR_W'(1);
      end
      if (ctrl.sum_sel) tmp_q <= acc_q + bus;
    end
  end

  assign opcode   = opcode_e'(ir_q[DATA_W-1 -: OP_W]);
  assign acc_zero = (acc_q == '0);
  assign mar      = mar_q;
  assign mdr      = mdr_q;
  assign acc      = acc_q;
  assign pc       = pc_q;

  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones({ctrl.acc_drv, ctrl.mdr_drv, ctrl.pc_drv, ctrl.tmp_drv, ctrl.ir_drv}) <= 1); // R8

  AST_PC_INCREMENT: assert property (@(posedge clk) disable iff (rst)
    ctrl.pc_inc |=> (pc_q == $past(pc_q) + ADDR_W'(1))); // R2

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.acc_ld |=> $stable(acc_q)); // R5

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctrl.pc_ld |=> (pc_q == $past(ir_q[ADDR_W-1:0]))); // R6

endmodule

// File: rtl/accpu_top.sv
module accpu_top
  import accpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pre_we,
  input  logic [DATA_W-OP_W-1:0]   pre_addr,
  input  logic [DATA_W-1:0]        pre_data,
  output logic [DATA_W-1:0]        dbg_acc,
  output logic [DATA_W-OP_W-1:0]   dbg_pc,
  output logic [STEP_W-1:0]        dbg_step
);

  localparam int unsigned ADDR_W = DATA_W - OP_W;

  ctrl_t             ctrl;
  opcode_e           opcode;
  logic              acc_zero;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] acc;
  logic [ADDR_W-1:0] pc;
  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] mem_rdata;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  // Preload owns the write port only while reset is held
  always_comb begin
    if (rst) begin
      mem_we    = pre_we;
      mem_waddr = pre_addr;
      mem_wdata = pre_data;
    end else begin
      mem_we    = ctrl.mem_wr;
      mem_waddr = mar;
      mem_wdata = mdr;
    end
  end

  accpu_wordmem #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (mem_rdata)
  );

  accpu_sequencer seq_i (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .acc_zero (acc_zero),
    .ctrl     (ctrl),
    .step     (step)
  );

  accpu_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .opcode    (opcode),
    .acc_zero  (acc_zero),
    .mar       (mar),
    .mdr       (mdr),
    .acc       (acc),
    .pc        (pc)
  );

  assign dbg_acc  = acc;
  assign dbg_pc   = pc;
  assign dbg_step = step;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && step == '0)); // R1

endmodule

// File: tb/accpu_top_tb_top.sv
module accpu_top_tb_top;

  localparam int DW    = 8;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [DW-1:0] dbg_acc;
  logic [AW-1:0] dbg_pc;
  logic [2:0]    dbg_step;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DW-1:0] img [DEPTH];
  logic [DW-1:0] mm  [DEPTH];
  logic [DW-1:0] m_acc;
  logic [AW-1:0] m_pc;

  always #2 clk = ~clk;

  accpu_top #(.DATA_W(DW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .dbg_acc  (dbg_acc),
    .dbg_pc   (dbg_pc),
    .dbg_step (dbg_step)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int op_cycles(input logic [1:0] op);
    case (op)
      2'b00:   return 6;
      2'b01:   return 7;
      2'b10:   return 6;
      default: return 4;
    endcase
  endfunction

  // Hold reset, write the image, then check the cleared state (R1)
  task automatic load_image();
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      pre_we   = 1'b1;
      pre_addr = AW'(a);
      pre_data = img[a];
      @(negedge clk);
    end
    pre_we = 1'b0;
    check(dbg_acc == '0, "R1 acc", int'(dbg_acc), 0);
    check(dbg_pc == '0, "R1 pc", int'(dbg_pc), 0);
    check(dbg_step == '0, "R1 step", int'(dbg_step), 0);
  endtask

  task automatic run_prog(input int n_instr, input bit directed);
    for (int a = 0; a < DEPTH; a++) mm[a] = img[a];
    m_acc = '0;
    m_pc  = '0;
    rst   = 1'b0;
    for (int k = 0; k < n_instr; k++) begin
      logic [DW-1:0] word;
      logic [1:0]    op;
      logic [AW-1:0] a;
      string         req;
      int            cyc;
      word = mm[m_pc];
      op   = word[7:6];
      a    = word[5:0];
      // Preload traffic while running must be ignored (R9)
      pre_we = 1'b1;
      if (directed) begin
        pre_addr = AW'(55);
        pre_data = 8'hEE;
      end else begin
        pre_addr = AW'($urandom);
        pre_data = DW'($urandom);
      end
      case (op)
        2'b00: begin m_acc = mm[a]; m_pc = m_pc + 1'b1; req = "R3"; end
        2'b01: begin m_acc = m_acc + mm[a]; m_pc = m_pc + 1'b1; req = "R4"; end
        2'b10: begin mm[a] = m_acc; m_pc = m_pc + 1'b1; req = "R5"; end
        default: begin
          if (m_acc == '0) begin m_pc = a; req = "R6"; end
          else begin m_pc = m_pc + 1'b1; req = "R7"; end
        end
      endcase
      cyc = op_cycles(op);
      repeat (cyc - 1) @(posedge clk);
      @(negedge clk);
      if (op == 2'b01) check(dbg_step == 3'd6, "R10 add last step", int'(dbg_step), 6);
      @(posedge clk);
      @(negedge clk);
      check(dbg_acc == m_acc, {req, " acc"}, int'(dbg_acc), int'(m_acc));
      check(dbg_pc == m_pc, {req, " pc"}, int'(dbg_pc), int'(m_pc));
      check(dbg_step == '0, "R2 step at boundary", int'(dbg_step), 0);
      if (directed && k == 7) check(dbg_acc == 8'h11, "R9 preload ignored", int'(dbg_acc), 17);
    end
    pre_we = 1'b0;
    rst    = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);

    // Directed program: wrap-around add, store/readback, both branch outcomes
    for (int a = 0; a < DEPTH; a++) img[a] = '0;
    img[0]  = {2'b00, 6'd50};
    img[1]  = {2'b01, 6'd51};
    img[2]  = {2'b10, 6'd52};
    img[3]  = {2'b00, 6'd53};
    img[4]  = {2'b00, 6'd52};
    img[5]  = {2'b11, 6'd9};
    img[6]  = {2'b00, 6'd54};
    img[7]  = {2'b00, 6'd55};
    img[8]  = {2'b00, 6'd53};
    img[9]  = {2'b11, 6'd20};
    img[20] = {2'b01, 6'd63};
    img[21] = {2'b10, 6'd56};
    img[50] = 8'd200;
    img[51] = 8'd100;
    img[54] = 8'h5A;
    img[55] = 8'h11;
    img[63] = 8'hFF;
    load_image();
    run_prog(12, 1'b1);

    // Random programs checked against the instruction-level model
    for (int p = 0; p < 6; p++) begin
      for (int a = 0; a < 32; a++) begin
        int r;
        r = $urandom % 10;
        if (r < 3)      img[a] = {2'b00, 1'b1, 5'($urandom)};
        else if (r < 6) img[a] = {2'b01, 1'b1, 5'($urandom)};
        else if (r < 8) img[a] = {2'b10, 1'b1, 5'($urandom)};
        else            img[a] = {2'b11, 1'b0, 5'($urandom)};
      end
      for (int a = 32; a < DEPTH; a++) begin
        img[a] = ($urandom % 3 == 0) ? 8'h00 : DW'($urandom);
      end
      load_image();
      run_prog(40, 1'b0);
    end

    load_image();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

endmodule